// File: doc/BRIEF.md
# Nibble-Bus Memory Read Target

This block is the target end of a narrow four-bit bus that multiplexes address and data, used to fetch firmware bytes. While the frame strobe is low, the host marks a cycle by placing nibble `0x0` on the bus. It then sends a cycle-type nibble and a 32-bit address as eight nibbles. Two turnaround clocks follow. The block then drives a ready nibble and returns one byte from a small internal array, low nibble first. It hands the bus back through a turnaround of its own.

The bus is split into an input, an output and an output enable, so the pad or tristate logic can sit outside the block. The array is filled through a valid/ready load port. `ld_ready` is high only while no bus cycle is in progress. A word is written on a clock edge where both `ld_valid` and `ld_ready` are high. While `ld_ready` is low the load source must hold its word: it is not taken, and it is not queued.

Top module: `nbt_target`

## Requirements
- R1: While `rst_n` is low, the block is idle: `nib_oe` is 0 and `ld_ready` is 1. Frame activity is ignored. A reset in mid-cycle returns the block to idle at once.
- R2: A cycle starts only on a clock edge where `frame_n` is 0 and `nib_in` is `0x0`. A low strobe that carries any other nibble leaves the block idle.
- R3: The nibble after the start, sampled with `frame_n` high, must be `4'b0100` (memory read). Any other value returns the block to idle, and the bus is not driven.
- R4: The address is taken as eight nibbles, most significant first. Address bits 7:0 select one of the 256 array bytes.
- R5: The block leaves `nib_oe` at 0 through the two host turnaround clocks. In the clock after them, it drives `0x0` with `nib_oe` at 1.
- R6: In the two clocks after the ready nibble, the block drives the selected byte: bits 3:0 first, then bits 7:4.
- R7: After the data, the block drives `0xF` for one clock. It drops `nib_oe` for one more clock, and is then idle again with `ld_ready` at 1.
- R8: A low `frame_n` in any clock of a cycle aborts the cycle. If the bus then carries `0x0`, that edge starts a new cycle. Otherwise the block goes idle.
- R9: `ld_ready` is 1 exactly when the block is idle. A load is written when `ld_valid` and `ld_ready` are both 1. A load offered while `ld_ready` is 0 leaves the array unchanged.
- R10: A new cycle may start in the first clock after a completed cycle returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| nib_in | input | 4 | Nibble seen on the shared bus |
| nib_out | output | 4 | Nibble the target drives |
| nib_oe | output | 1 | Target output enable for the bus |
| ld_valid | input | 1 | Load word offered to the array |
| ld_ready | output | 1 | Array accepts loads (block idle) |
| ld_addr | input | 8 | Array index of the load word |
| ld_data | input | 8 | Byte to store |

## Verification
Every fault in the sequencer's state or counters shows up as a shift of the ready nibble, data or release window relative to the host's clocks. The bench therefore checks `nib_oe` and `nib_out` on each of the five clocks after the host turnaround, in every read. A wrongly shifted or truncated address shows up in the same cycle's data byte, because each address reads a different array byte. The bench sweeps all 256 array entries with varied upper address bits to expose this. A stuck idle or busy state shows on `ld_ready` within one clock of the host stimulus that should have changed it.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_TAR_H,
    ST_TAR_Z,
    ST_SYNC,
    ST_DATA,
    ST_CTAR_F,
    ST_CTAR_Z
  } nbt_state_e;

  localparam logic [3:0] NIB_START   = 4'h0;
  localparam logic [3:0] NIB_MEMRD   = 4'b0100;
  localparam logic [3:0] NIB_READY   = 4'h0;
  localparam logic [3:0] NIB_RELEASE = 4'hF;
endpackage

// File: rtl/nbt_mem.sv
module nbt_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            frame_n,
  input  logic [3:0]                      nib_in,
  output nbt_state_e                      state,
  output logic [ADDR_W-1:0]               addr,
  output logic [$clog2(DATA_W/4 + 1)-1:0] dsel
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam int ACNT_W    = $clog2(ADDR_NIBS + 1);
  localparam int DCNT_W    = $clog2(DATA_NIBS + 1);

  logic [ACNT_W-1:0] acnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addr  <= '0;
      acnt  <= '0;
      dsel  <= '0;
    end else if (!frame_n) begin
      state <= (nib_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  state <= ST_IDLE;
        ST_CTYPE: begin
          acnt  <= '0;
          state <= (nib_in == NIB_MEMRD) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          addr <= {addr[ADDR_W-5:0], nib_in};
          acnt <= acnt + 1'b1;
          if (acnt == ACNT_W'(ADDR_NIBS - 1)) state <= ST_TAR_H;
        end
        ST_TAR_H: state <= ST_TAR_Z;
        ST_TAR_Z: state <= ST_SYNC;
        ST_SYNC: begin
          dsel  <= '0;
          state <= ST_DATA;
        end
        ST_DATA: begin
          dsel <= dsel + 1'b1;
          if (dsel == DCNT_W'(DATA_NIBS - 1)) state <= ST_CTAR_F;
        end
        ST_CTAR_F: state <= ST_CTAR_Z;
        ST_CTAR_Z: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbt_drive.sv
module nbt_drive
  import nbt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  nbt_state_e                      state,
  input  logic [DATA_W-1:0]               byte_q,
  input  logic [$clog2(DATA_W/4 + 1)-1:0] dsel,
  output logic [3:0]                      nib_out,
  output logic                            nib_oe
);
  localparam int DATA_NIBS = DATA_W / 4;

  logic [3:0] nibs [DATA_NIBS];

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_split
    assign nibs[g] = byte_q[4*g +: 4];
  end

  always_comb begin
    nib_out = 4'h0;
    nib_oe  = 1'b0;
    unique case (state)
      ST_SYNC: begin
        nib_out = NIB_READY;
        nib_oe  = 1'b1;
      end
      ST_DATA: begin
        nib_out = nibs[dsel];
        nib_oe  = 1'b1;
      end
      ST_CTAR_F: begin
        nib_out = NIB_RELEASE;
        nib_oe  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nbt_target.sv
module nbt_target
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  output logic [3:0]        nib_out,
  output logic              nib_oe,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data
);
  localparam int DCNT_W = $clog2(DATA_W/4 + 1);

  nbt_state_e        state;
  logic [ADDR_W-1:0] addr;
  logic [DCNT_W-1:0] dsel;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] byte_q;

  nbt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
    .state(state), .addr(addr), .dsel(dsel)
  );

  assign ld_ready = (state == ST_IDLE);

  nbt_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk(clk), .wr_en(ld_valid && ld_ready), .wr_addr(ld_addr),
    .wr_data(ld_data), .rd_addr(addr[MEM_AW-1:0]), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_q <= '0;
    else if (state == ST_TAR_Z && frame_n) byte_q <= rd_data;
  end

  nbt_drive #(.DATA_W(DATA_W)) u_drive (
    .state(state), .byte_q(byte_q), .dsel(dsel),
    .nib_out(nib_out), .nib_oe(nib_oe)
  );
endmodule

// File: rtl/nbt_target_chk.sv
module nbt_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] nib_out,
  input logic       nib_oe,
  input logic       ld_ready
);
  // R1: reset forces idle and a released bus
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (ld_ready && !nib_oe));

  // R2: with the strobe high, an idle block stays idle
  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && frame_n) |=> ld_ready);

  // R5: the first driven nibble is the ready code
  p_ready_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_oe) |-> (nib_out == 4'h0));

  // R6: the driver stays on for at most four clocks in a row
  p_drive_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nib_oe, 1) && $past(nib_oe, 2) && $past(nib_oe, 3) && $past(nib_oe, 4))
      |-> !nib_oe);

  // R7: without an abort, the driver turns off only after 0xF
  p_release_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nib_oe) && $past(frame_n)) |-> ($past(nib_out) == 4'hF));

  // R9: no drive while the load port is open
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !nib_oe);
endmodule

bind nbt_target nbt_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
  .nib_out(nib_out), .nib_oe(nib_oe), .ld_ready(ld_ready)
);

// File: tb/test_nbt_target.sv
module test_nbt_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] host_nib = 4'hF;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] nib_out;
  logic       nib_oe;
  logic       ld_ready;
  logic [3:0] nib_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  assign nib_in = nib_oe ? nib_out : host_nib;

  nbt_target i_nbt_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
    .nib_out(nib_out), .nib_oe(nib_oe), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic drive(bit f, logic [3:0] n);
    @(negedge clk);
    frame_n  = f;
    host_nib = n;
  endtask

  task automatic load(int a, logic [7:0] d);
    @(negedge clk);
    chk(ld_ready == 1'b1, "R9", "ready before load", int'(ld_ready), 1);
    ld_valid = 1'b1;
    ld_addr  = 8'(a);
    ld_data  = d;
  endtask

  task automatic read(logic [31:0] a, logic [7:0] exp, bit skip_start, bit poke);
    if (!skip_start) drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    if (poke) begin
      ld_valid = 1'b1;
      ld_addr  = a[7:0];
      ld_data  = ~exp;
    end
    for (int i = 0; i < 8; i++) drive(1'b1, a[31-4*i -: 4]);
    chk(ld_ready == 1'b0, "R9", "ready mid-cycle", int'(ld_ready), 0);
    drive(1'b1, 4'hF);
    chk(nib_oe == 1'b0, "R5", "oe in host turnaround", int'(nib_oe), 0);
    drive(1'b1, 4'h0);
    ld_valid = 1'b0;
    chk(nib_oe == 1'b0, "R5", "oe in released turnaround", int'(nib_oe), 0);
    @(negedge clk);
    chk(nib_oe && nib_out == 4'h0, "R5", "ready nibble", {nib_oe, nib_out}, 'h10);
    @(negedge clk);
    chk(nib_oe && nib_out == exp[3:0], "R6", "low data nibble", {nib_oe, nib_out}, {1'b1, exp[3:0]});
    @(negedge clk);
    chk(nib_oe && nib_out == exp[7:4], "R4 R6", "high data nibble", {nib_oe, nib_out}, {1'b1, exp[7:4]});
    @(negedge clk);
    chk(nib_oe && nib_out == 4'hF, "R7", "closing 0xF", {nib_oe, nib_out}, 'h1F);
    @(negedge clk);
    chk(nib_oe == 1'b0, "R7", "driver released", int'(nib_oe), 0);
    @(negedge clk);
    chk(ld_ready == 1'b1, "R7 R10", "idle after cycle", int'(ld_ready), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1: frame activity while reset is held
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    drive(1'b1, 4'h0);
    chk(ld_ready == 1'b1 && nib_oe == 1'b0, "R1", "idle in reset", {ld_ready, nib_oe}, 'b10);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: low strobe with a nonzero nibble does not start
    for (int v = 1; v < 16; v++) begin
      drive(1'b0, 4'(v));
      drive(1'b1, 4'hF);
      chk(ld_ready == 1'b1, "R2", "no start on nonzero", int'(ld_ready), 1);
    end

    // R9: preload every entry
    for (int i = 0; i < 256; i++) load(i, pat(i));
    @(negedge clk);
    ld_valid = 1'b0;

    // R4 R10: back-to-back reads of all entries, varied upper bits
    for (int i = 0; i < 256; i++)
      read({8'(i * 7 + 3), 8'(i ^ 'h5A), 8'(255 - i), 8'(i)}, pat(i), 1'b0, 1'b0);

    // R3: every non-read cycle type returns to idle without driving
    for (int t = 0; t < 16; t++) begin
      if (t == 4) continue;
      drive(1'b0, 4'h0);
      drive(1'b1, 4'(t));
      drive(1'b1, 4'h0);
      chk(ld_ready == 1'b1 && nib_oe == 1'b0, "R3", "bad type idle", {ld_ready, nib_oe}, 'b10);
      drive(1'b1, 4'h0);
      chk(nib_oe == 1'b0, "R3", "bad type no drive", int'(nib_oe), 0);
    end

    // R8: abort with nonzero nibble
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    drive(1'b1, 4'h1);
    drive(1'b1, 4'h2);
    drive(1'b0, 4'h3);
    drive(1'b1, 4'hF);
    chk(ld_ready == 1'b1 && nib_oe == 1'b0, "R8", "abort to idle", {ld_ready, nib_oe}, 'b10);

    // R8: abort with 0x0 restarts a full read
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    drive(1'b1, 4'h7);
    drive(1'b0, 4'h0);
    read(32'h1234_56C3, pat('hC3), 1'b1, 1'b0);

    // R9: load offered mid-cycle is ignored
    read(32'hFFFF_FF05, pat(5), 1'b0, 1'b1);
    read(32'h0000_0005, pat(5), 1'b0, 1'b0);

    // R1: reset in mid-cycle
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    drive(1'b1, 4'h0);
    rst_n = 1'b0;
    #1;
    chk(ld_ready == 1'b1 && nib_oe == 1'b0, "R1", "reset mid-cycle", {ld_ready, nib_oe}, 'b10);
    @(negedge clk);
    rst_n = 1'b1;
    read(32'h0000_0080, pat('h80), 1'b0, 1'b0);

    done = 1;
    summary();
  end
endmodule